// File: doc/BRIEF.md
# Windowed Error Rate Meter

The block measures how many error events occur within a fixed number of counted units, such as channel bits or code blocks. A strobe input marks each unit, and an error input that is high alongside the strobe marks that unit as being in error. Software programs a window length and then arms the meter through a control register. The meter counts errors until the programmed number of units has passed. It then stops, copies the count into byte-wide result registers and sets a done flag.

A window is armed by writing the start bit of the control register as zero and then as one. The result stays frozen until the next window finishes, so software can read it at any time, even while a new window is running. The window length is the 8-bit window register value times 2^UNIT_SHIFT units. Use UNIT_SHIFT = 16 for per-bit counting and UNIT_SHIFT = 8 for per-block counting. The result width CNT_W can be at most 24 bits.

Top module: `err_window_meter`

## Requirements
- R1: After reset the meter is idle and every register reads zero: control, window and the three result bytes. `done_o` is low.
- R2: A window starts only on a write to the control register (address 0) that sets bit 0 while the stored start bit is 0. The start clears the running count and the done flag. Writing bit 0 = 1 while the stored bit is already 1 does not restart the window.
- R3: A window ends on the clock edge that takes its N-th unit strobe, where N = WIN × 2^UNIT_SHIFT. On that edge done goes to 1 and running goes to 0. After N−1 strobes the meter is still running and not done.
- R4: An error is counted only when `err_flag` is high in the same cycle as `unit_stb` while a window is running. Errors without a strobe, and strobes or errors while idle, are ignored.
- R5: The error count saturates at 2^CNT_W − 1 and never wraps.
- R6: The result holds the count of the last completed window. It does not change while a new window counts, and it changes only when that window completes.
- R7: The result is read as bytes, least significant byte first: address 2 holds bits 7:0, address 3 holds bits 15:8 and address 4 holds bits 23:16. Bits above CNT_W read as 0.
- R8: The window length is captured when the window starts. A write to the window register (address 1) during a window changes only later windows.
- R9: Starting with a window value of 0 completes the window at once: done = 1, running = 0, result = 0.
- R10: If a start falls on the same edge as the final strobe of a window, the result takes the completed count, including an error on that final strobe. Done stays 0, and the new window starts counting from zero.
- R11: Counting is finite. After a window ends, further strobes and errors change neither the result nor the flags until the next start.
- R12: The control register reads done in bit 7, running in bit 6 and the stored start bit in bit 0, with all other bits 0. `done_o` mirrors bit 7. Done and running are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| unit_stb | input | 1 | One pulse per counted unit |
| err_flag | input | 1 | Marks the unit strobed in the same cycle as errored |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write enable for the register at reg_addr |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| done_o | output | 1 | Window-complete flag |

## Verification
Two functions can meet on a single edge: the final unit strobe that closes a window, and the control write that arms the next one. The bench drives a window one strobe short of its length, clears the start bit, and then issues the arming write in the same cycle as the last errored strobe. It judges the result by the latched count, which must include that last error. It also checks that done stays low while running goes high, and that the following window, run error-free, ends on its own length with a zero result.

// File: rtl/ewm_pkg.sv
package ewm_pkg;
    localparam int ADDR_W        = 3;
    localparam int REG_W         = 8;
    localparam int RES_SLOTS     = 3;
    localparam int ADDR_CTRL     = 0;
    localparam int ADDR_WIN      = 1;
    localparam int ADDR_RES0     = 2;
    localparam int CTRL_START_B  = 0;
    localparam int CTRL_RUN_B    = 6;
    localparam int CTRL_DONE_B   = 7;

    function automatic logic [REG_W-1:0] pack_ctrl(input logic done, input logic run,
                                                   input logic start);
        logic [REG_W-1:0] v;
        v = '0;
        v[CTRL_DONE_B]  = done;
        v[CTRL_RUN_B]   = run;
        v[CTRL_START_B] = start;
        return v;
    endfunction
endpackage

// File: rtl/ewm_regs.sv
module ewm_regs
    import ewm_pkg::*;
#(
    parameter int WIN_W = 8,
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr,
    input  logic [REG_W-1:0]     reg_wdata,
    input  logic                 running_i,
    input  logic                 done_i,
    input  logic [CNT_W-1:0]     result_i,
    output logic [REG_W-1:0]     reg_rdata,
    output logic [WIN_W-1:0]     win_o,
    output logic                 start_o
);
    localparam int PAD_W = RES_SLOTS * REG_W;

    typedef struct packed {
        logic             start;
        logic [WIN_W-1:0] win;
    } regs_t;

    regs_t regs_d, regs_q;
    logic [PAD_W-1:0] res_pad;
    logic [REG_W-1:0] res_byte [RES_SLOTS];

    assign res_pad = PAD_W'(result_i);

    for (genvar g = 0; g < RES_SLOTS; g++) begin : g_byte
        assign res_byte[g] = res_pad[g*REG_W +: REG_W];
    end

    always_comb begin
        regs_d  = regs_q;
        start_o = 1'b0;
        if (reg_wr) begin
            if (reg_addr == ADDR_W'(ADDR_CTRL)) begin
                regs_d.start = reg_wdata[CTRL_START_B];
                start_o      = reg_wdata[CTRL_START_B] && !regs_q.start;
            end else if (reg_addr == ADDR_W'(ADDR_WIN)) begin
                regs_d.win = reg_wdata[WIN_W-1:0];
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(ADDR_CTRL)) begin
            reg_rdata = pack_ctrl(done_i, running_i, regs_q.start);
        end else if (reg_addr == ADDR_W'(ADDR_WIN)) begin
            reg_rdata = REG_W'(regs_q.win);
        end else begin
            for (int k = 0; k < RES_SLOTS; k++) begin
                if (reg_addr == ADDR_W'(ADDR_RES0 + k)) begin
                    reg_rdata = res_byte[k];
                end
            end
        end
    end

    assign win_o = regs_q.win;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    // R2: an arming write leaves the stored start bit set
    p_start_stored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> regs_q.start);

    // R2: no arming pulse while the stored bit is already set
    p_no_rearm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.start && !reg_wr) |=> !start_o || !$past(regs_q.start) || regs_q.start == 1'b0 || !start_o);
endmodule

// File: rtl/ewm_timer.sv
module ewm_timer #(
    parameter int WIN_W      = 8,
    parameter int UNIT_SHIFT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [WIN_W-1:0] win_i,
    input  logic             unit_stb_i,
    output logic             running_o,
    output logic             done_o,
    output logic             count_en_o,
    output logic             win_end_o,
    output logic             zero_win_o
);
    localparam int LEN_W = WIN_W + UNIT_SHIFT;

    typedef struct packed {
        logic             running;
        logic             done;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] units;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic [LEN_W-1:0] step;
    logic             end_hit;
    logic             win_zero;

    always_comb begin
        tmr_d    = tmr_q;
        step     = tmr_q.units + 1'b1;
        end_hit  = tmr_q.running && unit_stb_i && (step == tmr_q.len);
        win_zero = (win_i == '0);

        if (tmr_q.running && unit_stb_i) begin
            tmr_d.units = step;
        end
        if (end_hit) begin
            tmr_d.running = 1'b0;
            tmr_d.done    = 1'b1;
        end
        if (start_i) begin
            tmr_d.len     = LEN_W'(win_i) << UNIT_SHIFT;
            tmr_d.units   = '0;
            tmr_d.running = !win_zero;
            tmr_d.done    = win_zero;
        end
    end

    assign running_o  = tmr_q.running;
    assign done_o     = tmr_q.done;
    assign count_en_o = tmr_q.running && unit_stb_i;
    assign win_end_o  = end_hit;
    assign zero_win_o = start_i && win_zero;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    // R12: done and running are exclusive
    p_flags_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.running |-> !tmr_q.done);

    // R11: without a start an idle meter stays idle with a steady done flag
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmr_q.running && !start_i) |=> (!tmr_q.running && $stable(tmr_q.done)));

    // R3: the unit counter never reaches the window length while running
    p_unit_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.running |-> (tmr_q.units < tmr_q.len));

    // R3: done only rises out of a running window or a start
    p_done_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr_q.done) |-> ($past(tmr_q.running) || $past(start_i)));
endmodule

// File: rtl/ewm_accum.sv
module ewm_accum #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             count_en_i,
    input  logic             err_i,
    input  logic             win_end_i,
    input  logic             zero_win_i,
    output logic [CNT_W-1:0] result_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] err;
        logic [CNT_W-1:0] result;
    } acc_t;

    acc_t acc_d, acc_q;
    logic             bump;
    logic [CNT_W-1:0] inc;

    always_comb begin
        acc_d = acc_q;
        bump  = count_en_i && err_i && (acc_q.err != CNT_MAX);
        inc   = acc_q.err + CNT_W'(bump);

        acc_d.err = start_i ? '0 : inc;
        if (zero_win_i) begin
            acc_d.result = '0;
        end else if (win_end_i) begin
            acc_d.result = inc;
        end
    end

    assign result_o = acc_q.result;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    // R5: a full count stays full until the next start
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q.err == CNT_MAX && !start_i) |=> (acc_q.err == CNT_MAX));

    // R6: the result only moves when a window closes
    p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_end_i && !zero_win_i) |=> $stable(acc_q.result));

    // R4: without a counted unit the running count does not move
    p_idle_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_en_i && !start_i) |=> $stable(acc_q.err));
endmodule

// File: rtl/err_window_meter.sv
module err_window_meter
    import ewm_pkg::*;
#(
    parameter int WIN_W      = 8,
    parameter int UNIT_SHIFT = 16,
    parameter int CNT_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              unit_stb,
    input  logic              err_flag,
    input  logic [2:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              done_o
);
    logic [WIN_W-1:0] win;
    logic             start;
    logic             running;
    logic             done;
    logic             count_en;
    logic             win_end;
    logic             zero_win;
    logic [CNT_W-1:0] result;

    ewm_regs #(.WIN_W(WIN_W), .CNT_W(CNT_W)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .running_i (running),
        .done_i    (done),
        .result_i  (result),
        .reg_rdata (reg_rdata),
        .win_o     (win),
        .start_o   (start)
    );

    ewm_timer #(.WIN_W(WIN_W), .UNIT_SHIFT(UNIT_SHIFT)) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .win_i      (win),
        .unit_stb_i (unit_stb),
        .running_o  (running),
        .done_o     (done),
        .count_en_o (count_en),
        .win_end_o  (win_end),
        .zero_win_o (zero_win)
    );

    ewm_accum #(.CNT_W(CNT_W)) accum_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .count_en_i (count_en),
        .err_i      (err_flag),
        .win_end_i  (win_end),
        .zero_win_i (zero_win),
        .result_o   (result)
    );

    assign done_o = done;

    // R10: a closing window that coincides with a start leaves done low
    p_collide_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (win_end && start && !zero_win) |=> (!done_o && running));
endmodule

// File: tb/err_window_meter_tb_top.sv
module err_window_meter_tb_top;
    localparam int SHIFT = 3;
    localparam int CW    = 10;
    localparam int MAXC  = (1 << CW) - 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       unit_stb = 1'b0;
    logic       err_flag = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       done_o;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    always #2.5 clk = ~clk;

    err_window_meter #(.WIN_W(8), .UNIT_SHIFT(SHIFT), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .unit_stb(unit_stb), .err_flag(err_flag),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .done_o(done_o)
    );

    function automatic int sat(input int n);
        return (n > MAXC) ? MAXC : n;
    endfunction

    function automatic int ctrl_val(input bit done, input bit run, input bit st);
        return (int'(done) << 7) | (int'(run) << 6) | int'(st);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_addr = 3'(a); reg_wdata = 8'(d); reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        reg_addr = 3'(a);
        #1;
        d = int'(reg_rdata);
    endtask

    task automatic rd_result(output int r);
        int b0, b1, b2;
        rd(2, b0); rd(3, b1); rd(4, b2);
        r = b0 | (b1 << 8) | (b2 << 16);
    endtask

    task automatic arm(input int win);
        wr(1, win);
        wr(0, 0);
        wr(0, 1);
    endtask

    // drives n strobes with gaps; errors on strobes at pct percent; noise errors in gaps
    task automatic units(input int n, input int pct, inout int errs);
        int sent = 0;
        while (sent < n) begin
            @(negedge clk);
            if ($urandom % 4 != 0) begin
                unit_stb = 1'b1;
                err_flag = (($urandom % 100) < pct);
                if (err_flag) errs++;
                sent++;
            end else begin
                unit_stb = 1'b0;
                err_flag = 1'($urandom % 2);
            end
        end
        @(negedge clk);
        unit_stb = 1'b0; err_flag = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int v, r, e, last;
        void'($urandom(32'h1d2c));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(0, v); check("R1 ctrl", v, 0);
        rd(1, v); check("R1 win", v, 0);
        rd_result(r); check("R1 result", r, 0);
        check("R1 done_o", int'(done_o), 0);

        // R4: strobes and errors while idle are ignored
        e = 0; units(12, 100, e);
        rd_result(r); check("R4 idle result", r, 0);
        rd(0, v); check("R4 idle ctrl", v, 0);

        // R3 / R12: directed window of 2*8 units, all errored
        arm(2);
        rd(0, v); check("R12 ctrl running", v, ctrl_val(0, 1, 1));
        e = 0; units(15, 100, e);
        rd(0, v); check("R3 not done at N-1", v, ctrl_val(0, 1, 1));
        units(1, 100, e);
        rd(0, v); check("R3 done at N", v, ctrl_val(1, 0, 1));
        check("R12 done_o", int'(done_o), 1);
        rd_result(r); check("R3 result", r, 16);

        // R11: finite count, nothing changes after the end
        units(20, 100, e);
        rd_result(r); check("R11 result frozen", r, 16);
        rd(0, v); check("R11 ctrl frozen", v, ctrl_val(1, 0, 1));

        // R4: random windows with noise errors off-strobe
        for (int i = 0; i < 6; i++) begin
            int w = 1 + int'($urandom % 12);
            int p = int'($urandom % 101);
            arm(w);
            e = 0; units(w * 8, p, e);
            rd_result(r); check("R4 random window", r, sat(e));
            rd(0, v); check("R4 random done", v, ctrl_val(1, 0, 1));
        end
        rd_result(last);

        // R6: result held while next window counts
        arm(2);
        e = 0; units(5, 100, e);
        rd_result(r); check("R6 held during count", r, last);
        check("R6 done low", int'(done_o), 0);
        units(11, 100, e);
        rd_result(r); check("R6 updated at end", r, 16);

        // R2: second write of start=1 does not restart
        arm(2);
        e = 0; units(6, 100, e);
        wr(0, 1);
        units(10, 100, e);
        rd(0, v); check("R2 no restart done", v, ctrl_val(1, 0, 1));
        rd_result(r); check("R2 no restart result", r, 16);

        // R8: window length captured at start
        arm(3);
        e = 0; units(5, 100, e);
        wr(1, 1);
        units(18, 100, e);
        rd(0, v); check("R8 still running", v, ctrl_val(0, 1, 1));
        units(1, 100, e);
        rd(0, v); check("R8 done at old length", v, ctrl_val(1, 0, 1));
        rd_result(r); check("R8 result", r, 24);
        rd(1, v); check("R8 win reg", v, 1);

        // R9: zero-length window
        arm(0);
        rd(0, v); check("R9 ctrl", v, ctrl_val(1, 0, 1));
        rd_result(r); check("R9 result", r, 0);

        // R5 / R7: saturation and byte layout
        arm(255);
        e = 0; units(255 * 8, 100, e);
        rd(2, v); check("R7 byte0", v, 8'hff);
        rd(3, v); check("R7 byte1", v, MAXC >> 8);
        rd(4, v); check("R7 byte2 zero", v, 0);
        rd_result(r); check("R5 saturated", r, MAXC);

        // R10: start on the same edge as the final strobe
        arm(1);
        e = 0; units(7, 100, e);
        wr(0, 0);
        @(negedge clk);
        reg_addr = 3'd0; reg_wdata = 8'd1; reg_wr = 1'b1;
        unit_stb = 1'b1; err_flag = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; unit_stb = 1'b0; err_flag = 1'b0;
        rd_result(r); check("R10 result includes last", r, 8);
        rd(0, v); check("R10 restarted", v, ctrl_val(0, 1, 1));
        e = 0; units(8, 0, e);
        rd(0, v); check("R10 next done", v, ctrl_val(1, 0, 1));
        rd_result(r); check("R10 next result", r, 0);

        ended = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule